// File: doc/BRIEF.md
# Canonic Signed Digit Recoder

This block turns a binary word into its canonic signed digit form. That form is a radix-2 code whose digits are -1, 0 or +1, no two neighbouring digits are both nonzero, and the number of nonzero digits is as small as it can be. Multiplier and filter datapaths use it to cut down the number of partial products. A mode input says whether the word is unsigned or two's complement. In unsigned mode one extra digit above the top input bit carries any final carry. Each digit leaves the block as a two-bit pair {sign, data}.

The carry that decides each digit does not come from a single majority ripple. It comes from two separate AND/OR chains that alternate by bit parity. Inside a group of four bits these chains ripple. Across groups a generate/propagate look-ahead moves them on four bits per step. An optional output register holds the digits for one clock.

Top module: `csd_recoder`

## Requirements
- R1: Digit i sits at bits [2i+1:2i] of the output as {sign, data}. The value 00 is zero, 01 is +1 and 10 is -1. The pair 11 is never produced.
- R2: When `isSigned` is 1, the sum of digit i times 2^i over digits 0..WIDTH-1 equals the input read as two's complement. Digit WIDTH is 00.
- R3: When `isSigned` is 0, the sum of digit i times 2^i over digits 0..WIDTH equals the input read as unsigned.
- R4: No two adjacent digits are both nonzero.
- R5: When `isSigned` is 0, digits WIDTH and WIDTH-1 are never -1.
- R6: Every digit matches the majority-carry recoding, as follows:
  - The carry is c_i = maj(x_{i+1}, x_i, c_{i-1}), with c_{-1} = 0.
  - The nonzero flag is d_i = x_i ^ c_{i-1}.
  - The data bit is ~x_{i+1} & d_i and the sign bit is x_{i+1} & d_i.
  - The bit above the top input bit is x_WIDTH. It equals x_{WIDTH-1} in signed mode and 0 in unsigned mode.
  - In unsigned mode the data bit of digit WIDTH equals c_{WIDTH-1}.
- R7: The group look-ahead values of both chains equal the values of a plain bit-by-bit ripple of the same chains at every bit index.
- R8: With REG_OUT=1, the digits for an input appear on `digitsOut` after the next rising clock edge. While `rstN` is low the output is all zeros.
- R9: The unsigned input 01010111 gives the digits 0,+1,0,-1,0,-1,0,0,-1, listed from digit 8 down to digit 0. All higher digits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| isSigned | input | 1 | 1: input is two's complement; 0: input is unsigned |
| dataIn | input | WIDTH | Binary word to recode |
| digitsOut | output | 2*(WIDTH+1) | Digit pairs {sign, data}, digit i at [2i+1:2i] |

## Verification
The hardest part to reach from the ports is the look-ahead step across groups. An error there shows only when a long run of ones crosses a four-bit group boundary while the propagate term is active, and the mistake then lands on the upper digits in only one of the two modes. The bench sweeps every 16-bit input in both modes. This covers every run length at every boundary position in both chains. Each result is compared with a majority-carry model and with the arithmetic value of the input.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef struct packed {
    logic extBit;   // value placed above the top input bit
    logic topEn;    // enables the extra top digit (unsigned mode)
  } csd_ctrl_t;
endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic      isSigned,
  input  logic      msbIn,
  output csd_ctrl_t ctrl
);
  always_comb begin
    ctrl.extBit = isSigned & msbIn;
    ctrl.topEn  = ~isSigned;
  end
endmodule

// File: rtl/csd_hk_chain.sv
module csd_hk_chain #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] h,
  output logic [WIDTH-1:0] k
);
  localparam int NGROUPS = WIDTH / 4;

  // Lower bits of each group ripple; bits 4j+6 jump through group look-ahead.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign h[i] = x[i];
      assign k[i] = 1'b0;
    end else if ((i % 4 == 2) && (i >= 6)) begin : g_look
      logic genH, propH, genK, propK;
      assign genH  = x[i] | (x[i-1] & x[i-2]);
      assign propH = x[i-1] & x[i-3];
      assign genK  = x[i] & (x[i-1] | x[i-2]);
      assign propK = x[i-1] | x[i-3];
      assign h[i]  = genH | (propH & h[i-4]);
      assign k[i]  = genK & (propK | k[i-4]);
    end else if (i % 2 == 0) begin : g_even
      assign h[i] = x[i] | h[i-1];
      assign k[i] = x[i] & k[i-1];
    end else begin : g_odd
      assign h[i] = x[i] & h[i-1];
      assign k[i] = x[i] | k[i-1];
    end
  end

  // Plain ripple of both chains, kept only for comparison.
  logic [WIDTH-1:0] hRip, kRip;
  always_comb begin
    logic hp, kp;
    hp = 1'b0;
    kp = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i % 2 == 0) begin
        hp = x[i] | hp;
        kp = x[i] & kp;
      end else begin
        hp = x[i] & hp;
        kp = x[i] | kp;
      end
      hRip[i] = hp;
      kRip[i] = kp;
    end
  end

  assert_lookahead_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (h == hRip) && (k == kRip))
    else $error("look-ahead chain differs from ripple (groups=%0d)", NGROUPS);
endmodule

// File: rtl/csd_digits.sv
module csd_digits
  import csd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH-1:0]     x,
  input  csd_ctrl_t            ctrl,
  output logic [2*WIDTH+1:0]   digits
);
  localparam int DW = 2 * (WIDTH + 1);

  logic [WIDTH:0]   xe;
  logic [WIDTH-1:0] h, k, carry, nz;

  assign xe = {ctrl.extBit, x};

  csd_hk_chain #(.WIDTH(WIDTH)) chain_i (
    .clk (clk),
    .rstN(rstN),
    .x   (x),
    .h   (h),
    .k   (k)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_dig
    if (i % 2 == 1) begin : g_codd
      assign carry[i] = h[i] | (xe[i+1] & k[i]);
    end else begin : g_ceven
      assign carry[i] = (xe[i+1] & h[i]) | k[i];
    end
    if (i == 0) begin : g_nz0
      assign nz[i] = x[i];
    end else begin : g_nzn
      assign nz[i] = x[i] ^ carry[i-1];
    end
    assign digits[2*i]   = ~xe[i+1] & nz[i];
    assign digits[2*i+1] =  xe[i+1] & nz[i];
  end

  assign digits[DW-2] = ctrl.topEn & carry[WIDTH-1];
  assign digits[DW-1] = 1'b0;
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 isSigned,
  input  logic [WIDTH-1:0]     dataIn,
  output logic [2*WIDTH+1:0]   digitsOut
);
  localparam int NDIG = WIDTH + 1;
  localparam int DW   = 2 * NDIG;

  csd_ctrl_t       ctrl;
  logic [DW-1:0]   digitsComb;

  csd_ctrl ctrl_i (
    .isSigned(isSigned),
    .msbIn   (dataIn[WIDTH-1]),
    .ctrl    (ctrl)
  );

  csd_digits #(.WIDTH(WIDTH)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .x     (dataIn),
    .ctrl  (ctrl),
    .digits(digitsComb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) digitsOut <= '0;
      else       digitsOut <= digitsComb;
    end
  end else begin : g_wire
    assign digitsOut = digitsComb;
  end

  // Per-digit views for the checks below.
  logic [NDIG-1:0] signV, dataV, nzV;
  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      signV[i] = digitsComb[2*i+1];
      dataV[i] = digitsComb[2*i];
    end
    nzV = signV ^ dataV;
  end

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_no_pair11_R1: assert property (@(posedge clk) disable iff (!rstN)
    (signV & dataV) == '0);
  assert_no_adjacent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (nzV[NDIG-1:1] & nzV[NDIG-2:0]) == '0);
  assert_signed_top_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    isSigned |-> (signV[NDIG-1] == 1'b0 && dataV[NDIG-1] == 1'b0));
  assert_unsigned_top_pos_R5: assert property (@(posedge clk) disable iff (!rstN)
    !isSigned |-> (signV[NDIG-1] == 1'b0 && signV[NDIG-2] == 1'b0));
  assert_reg_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (REG_OUT && pastValid) |-> (digitsOut == $past(digitsComb)));
endmodule

// File: tb/csd_recoder_tb.sv
module csd_recoder_tb_top;
  localparam int W          = 16;
  localparam int DW         = 2 * (W + 1);
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 199000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          isSigned = 1'b0;
  logic [W-1:0]  dataIn = '0;
  logic [DW-1:0] digitsOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csd_recoder #(.WIDTH(W), .REG_OUT(1'b1)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .isSigned (isSigned),
    .dataIn   (dataIn),
    .digitsOut(digitsOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expect1(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Majority-carry model of the recoding.
  function automatic logic [DW-1:0] refDigits(input logic sgn, input logic [W-1:0] v);
    logic [W:0] xe;
    logic c, d;
    logic [DW-1:0] r;
    xe = {sgn & v[W-1], v};
    c = 1'b0;
    r = '0;
    for (int i = 0; i < W; i++) begin
      d = xe[i] ^ c;
      r[2*i]   = ~xe[i+1] & d;
      r[2*i+1] =  xe[i+1] & d;
      c = (xe[i+1] & xe[i]) | (xe[i+1] & c) | (xe[i] & c);
    end
    r[DW-2] = ~sgn & c;
    return r;
  endfunction

  task automatic checkVec(input logic sgn, input logic [W-1:0] v);
    logic [DW-1:0] exp;
    longint sum, want;
    int pair11, adj;
    exp = refDigits(sgn, v);
    checks++;
    if (digitsOut !== exp) begin
      failures++;
      $display("FAIL R6 in=%h signed=%0b: actual=%h expected=%h", v, sgn, digitsOut, exp);
    end
    sum = 0; pair11 = 0; adj = 0;
    for (int i = 0; i <= W; i++) begin
      if (digitsOut[2*i] && !digitsOut[2*i+1]) sum += (longint'(1) << i);
      if (digitsOut[2*i+1] && !digitsOut[2*i]) sum -= (longint'(1) << i);
      if (digitsOut[2*i] && digitsOut[2*i+1]) pair11++;
      if (i > 0 && (digitsOut[2*i] | digitsOut[2*i+1]) &&
          (digitsOut[2*i-2] | digitsOut[2*i-1])) adj++;
    end
    want = sgn ? longint'($signed(v)) : longint'(v);
    expect1(sgn ? "R2 value" : "R3 value", sum, want);
    expect1("R1 pair11 count", pair11, 0);
    expect1("R4 adjacent count", adj, 0);
    if (sgn) expect1("R2 top digit", longint'(digitsOut[DW-1:DW-2]), 0);
    else expect1("R5 top signs", longint'({digitsOut[DW-1], digitsOut[DW-3]}), 0);
  endtask

  initial begin
    // R8: reset holds the output at zero whatever the input.
    dataIn = 16'hFFFF;
    isSigned = 1'b0;
    repeat (3) @(negedge clk);
    expect1("R8 reset output", longint'(digitsOut), 0);
    rstN = 1'b1;

    // R9: unsigned 0x57 recodes to a known digit string.
    dataIn = 16'h0057;
    isSigned = 1'b0;
    @(negedge clk);
    expect1("R9 example", longint'(digitsOut),
            longint'({16'd0, 18'b00_01_00_10_00_10_00_00_10}));

    // R8: output follows a new input after exactly one edge.
    dataIn = 16'h0003;
    @(negedge clk);
    expect1("R8 one-edge latency", longint'(digitsOut), longint'(refDigits(1'b0, 16'h0003)));

    // R6, R7 reached via every input in both modes (R2, R3, R1, R4, R5 per vector).
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 65536; v++) begin
        isSigned = m[0];
        dataIn = v[W-1:0];
        @(negedge clk);
        checkVec(m[0], v[W-1:0]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule